// File: doc/BRIEF.md
# Process Timeout Scanner

The scanner keeps a coarse 16-bit time value for a process scheduler and wakes processes whose wait deadline has arrived. A periodic tick input is divided down. On each divided step the time advances by one and a pass runs over the process table held in a shared word-addressed memory. The pass first reads the number of process blocks. It then reads each block's deadline word and compares it with the time captured when the pass began. A block whose deadline matches has its deadline word cleared and its waiting flag dropped. The block's handle is then offered to the queue engine over a valid/ready port. That port means "move this process to the ready queue; its current queue is unknown".

The block also exposes the deadline rule that a process uses when it starts a wait. The requested interval is added to the present time, wrapping at 16 bits. A zero interval means "wait forever". A sum that lands on zero is moved to one, so that a real deadline never looks like "forever". The time counter itself wraps modulo 2^16.

Top module: `timeout_scanner`

## Requirements
- R1: After reset the time output is 0, no memory request and no requeue request is raised, and the done pulse is low.
- R2: The time output increments by exactly one on every third tick pulse and does not change on the other tick pulses.
- R3: Each divided step starts one pass. The pass reads the block count from word address 1, then reads the deadline word at address 0x40 + 4*i + 3 for every i from 0 to count-1, in increasing order, and reads no other deadline words.
- R4: A block whose deadline word is 0 is never treated as expired and its memory words are left unchanged.
- R5: A block expires only when its nonzero deadline word equals the time captured at the start of the pass; a deadline above or below that time leaves the block untouched.
- R6: For an expired block the scanner writes 0 to the deadline word. It then rewrites the flags word at 0x40 + 4*i + 1 with bit 1 (waiting) cleared and every other bit preserved. Both writes finish before the requeue request is raised.
- R7: Each expired block produces one requeue request whose handle is the block's base address 0x40 + 4*i, in scan order. The request stays raised with a stable handle until the engine accepts it.
- R8: The deadline output is 0 when the requested interval is 0, and otherwise is the current time plus the interval modulo 2^16.
- R9: When the time-plus-interval sum wraps to exactly 0, the deadline output is 1.
- R10: A step that arrives while a pass is still running starts no pass of its own; the time still advances. Every pass ends with a done pulse one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic tick pulse, one cycle per tick |
| now_o | output | 16 | Current coarse time |
| wait_ticks_i | input | 16 | Requested wait interval, 0 = forever |
| deadline_o | output | 16 | Deadline computed from now_o and wait_ticks_i |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| rq_valid_o | output | 1 | Requeue request to the queue engine (NIL source, ready destination) |
| rq_handle_o | output | 16 | Base address of the process block to requeue |
| rq_ready_i | input | 1 | Queue engine accepts the request |
| scan_done_o | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The bench fills a small process table with deadlines that are zero, equal to the pass time, and just above or below it. A design that compared with "less or equal", or that treated zero as a match, would raise extra requeues, and the scoreboard would flag the unexpected handles. It checks that flags bits other than the waiting bit survive the rewrite, and that only the first pass of every three ticks counts. It stalls the engine across a whole divided step to show that the overlapping step is skipped, not queued, and that a deadline equal to the skipped time stays untouched. Deadline checks cover a zero interval, an ordinary sum and a sum that wraps exactly onto zero.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CNT_RD,
    S_CNT_WT,
    S_TO_RD,
    S_TO_WT,
    S_TO_CLR,
    S_FL_RD,
    S_FL_WT,
    S_FL_WR,
    S_REQ,
    S_DONE
  } scan_st_e;

endpackage

// File: rtl/ts_tick_div.sv
module ts_tick_div #(
  parameter int DIV    = 3,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic              step_o,
  output logic [TIME_W-1:0] time_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      step_o <= 1'b0;
      time_o <= '0;
    end else begin
      step_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          step_o <= 1'b1;
          time_o <= time_o + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ts_deadline.sv
module ts_deadline #(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] interval_i,
  output logic [TIME_W-1:0] deadline_o
);

  logic [TIME_W-1:0] sum;

  always_comb begin
    sum = now_i + interval_i;
    if (interval_i == '0)
      deadline_o = '0;
    else if (sum == '0)
      deadline_o = TIME_W'(1);
    else
      deadline_o = sum;
  end

endmodule

// File: rtl/ts_scan_ctrl.sv
module ts_scan_ctrl
  import ts_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int COUNT_ADDR  = 1,
  parameter int BLOCK_BASE  = 'h40,
  parameter int STRIDE_LG2  = 2,
  parameter int FLAGS_OFS   = 1,
  parameter int TIMEOUT_OFS = 3,
  parameter int WAIT_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [DATA_W-1:0] time_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rq_valid_o,
  output logic [ADDR_W-1:0] rq_handle_o,
  input  logic              rq_ready_i,
  output logic              done_o
);

  localparam logic [DATA_W-1:0] WAIT_MASK = DATA_W'(1) << WAIT_BIT;

  scan_st_e          state_q;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] stamp_q;
  logic [DATA_W-1:0] flags_q;

  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] idx_nx;
  logic              last;

  assign base   = ADDR_W'(BLOCK_BASE) + (ADDR_W'(idx_q) << STRIDE_LG2);
  assign idx_nx = idx_q + 1'b1;
  assign last   = (idx_nx == count_q);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_CNT_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ADDR_W'(COUNT_ADDR);
      end
      S_TO_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base + ADDR_W'(TIMEOUT_OFS);
      end
      S_TO_CLR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = base + ADDR_W'(TIMEOUT_OFS);
      end
      S_FL_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base + ADDR_W'(FLAGS_OFS);
      end
      S_FL_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base + ADDR_W'(FLAGS_OFS);
        mem_wdata_o = flags_q & ~WAIT_MASK;
      end
      default: ;
    endcase
  end

  assign rq_valid_o  = (state_q == S_REQ);
  assign rq_handle_o = base;
  assign done_o      = (state_q == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      count_q <= '0;
      stamp_q <= '0;
      flags_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (step_i) begin
          stamp_q <= time_i;
          state_q <= S_CNT_RD;
        end
        S_CNT_RD: state_q <= S_CNT_WT;
        S_CNT_WT: begin
          count_q <= mem_rdata_i;
          idx_q   <= '0;
          state_q <= (mem_rdata_i == '0) ? S_DONE : S_TO_RD;
        end
        S_TO_RD: state_q <= S_TO_WT;
        S_TO_WT: begin
          if (mem_rdata_i != '0 && mem_rdata_i == stamp_q)
            state_q <= S_TO_CLR;
          else if (last)
            state_q <= S_DONE;
          else begin
            idx_q   <= idx_nx;
            state_q <= S_TO_RD;
          end
        end
        S_TO_CLR: state_q <= S_FL_RD;
        S_FL_RD:  state_q <= S_FL_WT;
        S_FL_WT: begin
          flags_q <= mem_rdata_i;
          state_q <= S_FL_WR;
        end
        S_FL_WR: state_q <= S_REQ;
        S_REQ: if (rq_ready_i) begin
          if (last)
            state_q <= S_DONE;
          else begin
            idx_q   <= idx_nx;
            state_q <= S_TO_RD;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/timeout_scanner.sv
module timeout_scanner #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int TICK_DIV    = 3,
  parameter int COUNT_ADDR  = 1,
  parameter int BLOCK_BASE  = 'h40,
  parameter int STRIDE_LG2  = 2,
  parameter int FLAGS_OFS   = 1,
  parameter int TIMEOUT_OFS = 3,
  parameter int WAIT_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic [DATA_W-1:0] now_o,
  input  logic [DATA_W-1:0] wait_ticks_i,
  output logic [DATA_W-1:0] deadline_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rq_valid_o,
  output logic [ADDR_W-1:0] rq_handle_o,
  input  logic              rq_ready_i,
  output logic              scan_done_o
);

  logic step;

  ts_tick_div #(
    .DIV   (TICK_DIV),
    .TIME_W(DATA_W)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick_i),
    .step_o(step),
    .time_o(now_o)
  );

  ts_deadline #(
    .TIME_W(DATA_W)
  ) u_deadline (
    .now_i     (now_o),
    .interval_i(wait_ticks_i),
    .deadline_o(deadline_o)
  );

  ts_scan_ctrl #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .COUNT_ADDR (COUNT_ADDR),
    .BLOCK_BASE (BLOCK_BASE),
    .STRIDE_LG2 (STRIDE_LG2),
    .FLAGS_OFS  (FLAGS_OFS),
    .TIMEOUT_OFS(TIMEOUT_OFS),
    .WAIT_BIT   (WAIT_BIT)
  ) u_scan (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .time_i     (now_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .rq_valid_o (rq_valid_o),
    .rq_handle_o(rq_handle_o),
    .rq_ready_i (rq_ready_i),
    .done_o     (scan_done_o)
  );

endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int STRIDE_LG2  = 2,
  parameter int TIMEOUT_OFS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] now_o,
  input logic [DATA_W-1:0] wait_ticks_i,
  input logic [DATA_W-1:0] deadline_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              rq_valid_o,
  input logic [ADDR_W-1:0] rq_handle_o,
  input logic              rq_ready_i,
  input logic              scan_done_o
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << STRIDE_LG2) - 1);
  localparam logic [ADDR_W-1:0] TO_LOW   = ADDR_W'(TIMEOUT_OFS);

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(now_o) |-> now_o == $past(now_o) + 1'b1); // R2

  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o); // R3

  AST_TIMEOUT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && ((mem_addr_o & LOW_MASK) == TO_LOW)) |-> mem_wdata_o == '0); // R6

  AST_RQ_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    rq_valid_o |-> !mem_req_o); // R6

  AST_RQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rq_valid_o && !rq_ready_i) |=> (rq_valid_o && $stable(rq_handle_o))); // R7

  AST_FOREVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wait_ticks_i == '0) |-> deadline_o == '0); // R8

  AST_DEADLINE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (wait_ticks_i != '0) |-> deadline_o != '0); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    scan_done_o |=> !scan_done_o); // R10

endmodule

bind timeout_scanner ts_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STRIDE_LG2 (STRIDE_LG2),
  .TIMEOUT_OFS(TIMEOUT_OFS)
) u_chk (.*);

// File: tb/test_timeout_scanner.sv
module test_timeout_scanner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] now;
  logic [15:0] wait_ticks = 16'd0;
  logic [15:0] deadline;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'd0;
  logic        rq_valid;
  logic [15:0] rq_handle;
  logic        rq_ready = 1'b0;
  logic        scan_done;

  always #4 clk = ~clk;

  timeout_scanner i_timeout_scanner (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .now_o       (now),
    .wait_ticks_i(wait_ticks),
    .deadline_o  (deadline),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .rq_valid_o  (rq_valid),
    .rq_handle_o (rq_handle),
    .rq_ready_i  (rq_ready),
    .scan_done_o (scan_done)
  );

  logic [15:0] mem [0:255];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end

  int n_cmp = 0, n_bad = 0;
  int done_n = 0, rd_n = 0, to_rd_n = 0, wait_n = 0;
  bit stall = 1'b0;
  logic [15:0] exp_q[$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_rq(input logic [15:0] h);
    exp_q.push_back(h);
  endtask

  // monitor: engine model and scoreboard
  always @(negedge clk) begin
    if (scan_done) done_n++;
    if (mem_req && !mem_we) begin
      rd_n++;
      if (mem_addr[1:0] == 2'd3) to_rd_n++;
    end
    if (rq_valid) begin
      rq_ready = !stall && (wait_n >= 2);
      if (rq_ready) begin
        wait_n = 0;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7: actual unexpected handle %h expected none", rq_handle);
        end else chk("R7 requeue handle", rq_handle, exp_q.pop_front());
      end else wait_n++;
    end else begin
      rq_ready = 1'b0;
      wait_n   = 0;
    end
  end

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done(input int start);
    int g = 0;
    while (done_n == start && g < 3000) begin
      @(negedge clk);
      g++;
    end
    if (g >= 3000) chk("R10 pass end", 16'(done_n), 16'(start + 1));
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int d0;
    for (int a = 0; a < 256; a++) mem[a] = 16'd0;
    mem[1]    = 16'd4;       // block count
    mem[8'h41] = 16'h0007; mem[8'h43] = 16'd1;  // block 0
    mem[8'h45] = 16'h0002; mem[8'h47] = 16'd0;  // block 1: forever
    mem[8'h49] = 16'h8002; mem[8'h4B] = 16'd2;  // block 2
    mem[8'h4D] = 16'h0002; mem[8'h4F] = 16'd1;  // block 3

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 time", now, 16'd0);
    chk("R1 mem_req", 16'(mem_req), 16'd0);
    chk("R1 rq_valid", 16'(rq_valid), 16'd0);
    chk("R1 done", 16'(scan_done), 16'd0);

    // first two ticks: nothing happens
    pulse_tick(); pulse_tick();
    repeat (4) @(negedge clk);
    chk("R2 time after 2 ticks", now, 16'd0);
    chk("R3 no access before step", 16'(rd_n), 16'd0);

    // third tick: pass at time 1
    expect_rq(16'h0040);
    expect_rq(16'h004C);
    d0 = done_n;
    pulse_tick();
    wait_done(d0);
    chk("R2 time after 3 ticks", now, 16'd1);
    chk("R3 deadline reads", 16'(to_rd_n), 16'd4);
    chk("R3 total reads", 16'(rd_n), 16'd7);
    chk("R6 block0 deadline", mem[8'h43], 16'd0);
    chk("R6 block0 flags", mem[8'h41], 16'h0005);
    chk("R6 block3 deadline", mem[8'h4F], 16'd0);
    chk("R6 block3 flags", mem[8'h4D], 16'h0000);
    chk("R4 block1 deadline", mem[8'h47], 16'd0);
    chk("R4 block1 flags", mem[8'h45], 16'h0002);
    chk("R5 block2 untouched", mem[8'h4B], 16'd2);
    chk("R7 scoreboard drained", 16'(exp_q.size()), 16'd0);

    // pass at time 2: above and below do not match
    mem[8'h47] = 16'd5; mem[8'h4F] = 16'd1;
    expect_rq(16'h0048);
    d0 = done_n;
    repeat (3) pulse_tick();
    wait_done(d0);
    chk("R2 time 2", now, 16'd2);
    chk("R6 block2 flags", mem[8'h49], 16'h8000);
    chk("R6 block2 deadline", mem[8'h4B], 16'd0);
    chk("R5 above kept", mem[8'h47], 16'd5);
    chk("R5 below kept", mem[8'h4F], 16'd1);
    chk("R7 scoreboard drained", 16'(exp_q.size()), 16'd0);

    // overlapping step is skipped
    mem[8'h43] = 16'd3; mem[8'h41] = 16'h0002;
    mem[8'h4F] = 16'd4;
    stall = 1'b1;
    expect_rq(16'h0040);
    d0 = done_n;
    repeat (3) pulse_tick();
    begin
      int g = 0;
      while (!rq_valid && g < 500) begin @(negedge clk); g++; end
    end
    chk("R7 request raised", 16'(rq_valid), 16'd1);
    repeat (3) pulse_tick();
    chk("R10 time still advances", now, 16'd4);
    chk("R7 request held", 16'(rq_valid), 16'd1);
    stall = 1'b0;
    wait_done(d0);
    repeat (20) @(negedge clk);
    chk("R10 single pass", 16'(done_n - d0), 16'd1);
    chk("R10 skipped deadline kept", mem[8'h4F], 16'd4);
    chk("R6 block0 cleared", mem[8'h43], 16'd0);
    chk("R7 scoreboard drained", 16'(exp_q.size()), 16'd0);

    // deadline rule at time 4
    wait_ticks = 16'd0;    #1; chk("R8 forever", deadline, 16'd0);
    wait_ticks = 16'd10;   #1; chk("R8 sum", deadline, 16'd14);
    wait_ticks = 16'hFFFF; #1; chk("R8 plain wrap", deadline, 16'd3);
    wait_ticks = 16'hFFFC; #1; chk("R9 wrap to zero", deadline, 16'd1);

    summary();
    $finish;
  end

endmodule